// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Change Interrupt

This block is the general-purpose port behind a two-wire bus target. It has no direction register. Each pin is either a weak pull-up, when its output latch bit is 1, or a strong low, when the bit is 0. A pin latched high can be driven by outside logic and then works as an input. Each time the bus front end writes a 1 to a bit, that pin also gets a short strong pull-up pulse. The pulse lasts until the next falling edge of the bus clock, so a heavily loaded line rises quickly.

Pin levels pass through a synchronizer before any use. They are compared against a baseline byte, and the block raises an active-low open-drain interrupt when any synchronized pin differs from that baseline. The front end reports acknowledge-phase events for a port read and for a port write. Either event clears the interrupt and takes the present pin levels as the new baseline. After a clear, a fresh difference is held back until the next rising bus clock edge. A separate read-capture strobe loads the byte that is returned on a port read.

The front end only pulses the acknowledge and capture strobes for transactions addressed to this port. Traffic to other targets therefore never reaches the interrupt state.

Top module: `qbd_port`

## Requirements
- R1: After reset every latch bit is 1. So `pull_dn_en` is 0x00, `strong_pu_en` is 0x00, `irq_od_en` is 0, and `rd_data` and the interrupt baseline are 0xFF.
- R2: A `wr_stb` cycle loads `wr_data` into the latch. From the next cycle, `pull_dn_en[i]` is 1 exactly when latch bit i is 0.
- R3: A `wr_stb` cycle sets `strong_pu_en[i]` for every bit written 1 and clears it for every bit written 0. A set bit stays set until a `scl_fall` cycle and reads 0 from the cycle after it. A strong pull-up bit is never 1 together with the pull-down of the same pin.
- R4: When `wr_stb` and `scl_fall` fall in the same cycle, the write wins and the strong pull-up pulse starts.
- R5: A rising or a falling change on `pin_in` that makes the synchronized pins differ from the baseline sets `irq_od_en` to 1 (line pulled low). With two synchronizer stages, this happens after the third clock edge after the change.
- R6: An `ack_rd_rise` cycle (read acknowledge, after the rising bus clock edge) clears `irq_od_en` on the next cycle and loads the current synchronized pins as the baseline.
- R7: An `ack_wr_fall` cycle (write acknowledge, after the falling bus clock edge) clears `irq_od_en` on the next cycle and loads the current synchronized pins as the baseline.
- R8: When the synchronized pins return to the baseline, `irq_od_en` returns to 0 with no bus event.
- R9: After a clear, a difference from the baseline keeps `irq_od_en` at 0 until a `scl_rise` cycle. It is 1 from the cycle after that `scl_rise`.
- R10: `scl_rise`, `scl_fall`, `cap_stb` and `wr_stb` on their own never clear an asserted interrupt.
- R11: A `cap_stb` cycle loads the synchronized pin levels into `rd_data` on every bit, whatever the latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Port write strobe from the bus front end |
| wr_data | input | WIDTH | Byte to latch on a write |
| cap_stb | input | 1 | Load the read byte from the pins |
| ack_rd_rise | input | 1 | Read acknowledge event, after the rising bus clock edge |
| ack_wr_fall | input | 1 | Write acknowledge event, after the falling bus clock edge |
| scl_rise | input | 1 | Rising bus clock edge event |
| scl_fall | input | 1 | Falling bus clock edge event |
| pin_in | input | WIDTH | Raw sampled pin levels |
| pull_dn_en | output | WIDTH | Strong low enable per pin |
| strong_pu_en | output | WIDTH | Strong pull-up pulse enable per pin |
| rd_data | output | WIDTH | Captured read byte |
| irq_od_en | output | 1 | Open-drain interrupt enable (1 pulls the line low) |

## Verification
The bench builds the block with WIDTH of 8 and SYNC_STAGES of 2. With these values, the three-edge interrupt latency and the exact cycle of each clear can be checked against fixed cycle counts. A full byte also covers every mix of latched-low and latched-high pins within reach of both directed patterns and random patterns. A behavioural model is compared against all four outputs on every cycle. It covers same-cycle write and falling-edge collisions, and clears that land while pins are still changing.

// File: rtl/qbd_pkg.sv
package qbd_pkg;

  // Interrupt tracker states
  typedef enum logic [1:0] {
    IRQ_IDLE   = 2'd0,  // pins match the baseline, line released
    IRQ_ACTIVE = 2'd1,  // difference seen, line pulled low
    IRQ_HOLD   = 2'd2   // cleared, waiting for a rising bus clock edge
  } irq_state_e;

  // Reset value of a byte-wide register held high
  function automatic logic [63:0] all_ones();
    return '1;
  endfunction

endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '1;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign d_out = stage_q[LAST];

endmodule

// File: rtl/qbd_out_latch.sv
module qbd_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             scl_fall,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] strong_pu_en
);

  logic [WIDTH-1:0] lat_q, lat_d;
  logic [WIDTH-1:0] spu_q, spu_d;
  logic             lat_en, spu_en;

  assign lat_en = wr_stb;
  assign spu_en = wr_stb | scl_fall;

  // Next state: a write overrides the falling-edge release
  always_comb begin
    lat_d = lat_q;
    spu_d = spu_q;
    if (scl_fall) begin
      spu_d = '0;
    end
    if (wr_stb) begin
      lat_d = wr_data;
      spu_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '1;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spu_q <= '0;
    end else if (spu_en) begin
      spu_q <= spu_d;
    end
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pull_dn_en[i]   = ~lat_q[i];
      assign strong_pu_en[i] = spu_q[i] & lat_q[i];
    end
  endgenerate

endmodule

// File: rtl/qbd_change_irq.sv
module qbd_change_irq
  import qbd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_s,
  input  logic             cap_stb,
  input  logic             ack_rd_rise,
  input  logic             ack_wr_fall,
  input  logic             scl_rise,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] base_o,
  output logic             irq_od_en
);

  irq_state_e       state_q, state_d;
  logic [WIDTH-1:0] base_q, base_d;
  logic [WIDTH-1:0] rd_q, rd_d;
  logic [WIDTH-1:0] diff;
  logic             mism, clr;
  logic             base_en, rd_en;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
      assign diff[i] = pin_s[i] ^ base_q[i];
    end
  endgenerate

  assign mism    = |diff;
  assign clr     = ack_rd_rise | ack_wr_fall;
  assign base_en = clr;
  assign rd_en   = cap_stb;
  assign base_d  = pin_s;
  assign rd_d    = pin_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IRQ_IDLE: begin
        if (clr)       state_d = IRQ_HOLD;
        else if (mism) state_d = IRQ_ACTIVE;
      end
      IRQ_ACTIVE: begin
        if (clr)        state_d = IRQ_HOLD;
        else if (!mism) state_d = IRQ_IDLE;
      end
      IRQ_HOLD: begin
        if (clr)           state_d = IRQ_HOLD;
        else if (scl_rise) state_d = mism ? IRQ_ACTIVE : IRQ_IDLE;
      end
      default: state_d = IRQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IRQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '1;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '1;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data   = rd_q;
  assign base_o    = base_q;
  assign irq_od_en = (state_q == IRQ_ACTIVE);

endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cap_stb,
  input  logic             ack_rd_rise,
  input  logic             ack_wr_fall,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] strong_pu_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq_od_en
);

  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] base_v;

  qbd_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (pin_s)
  );

  qbd_out_latch #(
    .WIDTH (WIDTH)
  ) u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data),
    .scl_fall     (scl_fall),
    .pull_dn_en   (pull_dn_en),
    .strong_pu_en (strong_pu_en)
  );

  qbd_change_irq #(
    .WIDTH (WIDTH)
  ) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_s       (pin_s),
    .cap_stb     (cap_stb),
    .ack_rd_rise (ack_rd_rise),
    .ack_wr_fall (ack_wr_fall),
    .scl_rise    (scl_rise),
    .rd_data     (rd_data),
    .base_o      (base_v),
    .irq_od_en   (irq_od_en)
  );

endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_stb,
  input logic [W-1:0] wr_data,
  input logic         cap_stb,
  input logic         ack_rd_rise,
  input logic         ack_wr_fall,
  input logic         scl_fall,
  input logic [W-1:0] pin_s,
  input logic [W-1:0] base_v,
  input logic [W-1:0] pull_dn_en,
  input logic [W-1:0] strong_pu_en,
  input logic [W-1:0] rd_data,
  input logic         irq_od_en
);

  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (pull_dn_en == ~$past(wr_data))); // R2

  AST_PULSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (strong_pu_en == $past(wr_data))); // R4

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !wr_stb) |=> (strong_pu_en == '0)); // R3

  always_comb begin
    if (rst_n) begin
      AST_NO_FIGHT: assert ((strong_pu_en & pull_dn_en) == '0); // R3
    end
  end

  AST_RISE_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_od_en) |-> $past(pin_s != base_v)); // R5

  AST_READ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd_rise |=> !irq_od_en); // R6

  AST_WRITE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr_fall |=> (!irq_od_en && (base_v == $past(pin_s)))); // R7

  AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (rd_data == $past(pin_s))); // R11

endmodule

bind qbd_port qbd_port_chk #(.W(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_stb       (wr_stb),
  .wr_data      (wr_data),
  .cap_stb      (cap_stb),
  .ack_rd_rise  (ack_rd_rise),
  .ack_wr_fall  (ack_wr_fall),
  .scl_fall     (scl_fall),
  .pin_s        (pin_s),
  .base_v       (base_v),
  .pull_dn_en   (pull_dn_en),
  .strong_pu_en (strong_pu_en),
  .rd_data      (rd_data),
  .irq_od_en    (irq_od_en)
);

// File: tb/qbd_port_bench.sv
`timescale 1ns/1ps
module qbd_port_bench;

  localparam int W   = 8;
  localparam int STG = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         cap_stb = 1'b0;
  logic         ack_rd_rise = 1'b0;
  logic         ack_wr_fall = 1'b0;
  logic         scl_rise = 1'b0;
  logic         scl_fall = 1'b0;
  logic [W-1:0] pin_in = '1;
  logic [W-1:0] pull_dn_en, strong_pu_en, rd_data;
  logic         irq_od_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  qbd_port #(.WIDTH(W), .SYNC_STAGES(STG)) u_qbd_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data),
    .cap_stb      (cap_stb),
    .ack_rd_rise  (ack_rd_rise),
    .ack_wr_fall  (ack_wr_fall),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .pin_in       (pin_in),
    .pull_dn_en   (pull_dn_en),
    .strong_pu_en (strong_pu_en),
    .rd_data      (rd_data),
    .irq_od_en    (irq_od_en)
  );

  // Behavioural reference: pin history, latch, pulse, baseline, read byte
  logic [W-1:0] m_lat, m_spu, m_base, m_rd;
  logic [W-1:0] m_hist [STG];
  int           m_st;  // 0 quiet, 1 asserted, 2 held after clear
  logic [W-1:0] m_ps;
  bit           m_clr, m_diff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = '1; m_spu = '0; m_base = '1; m_rd = '1; m_st = 0;
      for (int k = 0; k < STG; k++) m_hist[k] = '1;
    end else begin
      m_ps   = m_hist[STG-1];
      m_clr  = ack_rd_rise || ack_wr_fall;
      m_diff = (m_ps != m_base);
      if (m_clr) m_st = 2;
      else if (m_st == 2) begin
        if (scl_rise) m_st = m_diff ? 1 : 0;
      end else m_st = m_diff ? 1 : 0;
      if (m_clr) m_base = m_ps;
      if (cap_stb) m_rd = m_ps;
      if (wr_stb) begin
        m_lat = wr_data; m_spu = wr_data;
      end else if (scl_fall) m_spu = '0;
      for (int k = STG-1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (live && rst_n) begin
      chk("R2 pull_dn_en model", pull_dn_en, ~m_lat);
      chk("R3 strong_pu_en model", strong_pu_en, m_spu & m_lat);
      chk("R11 rd_data model", rd_data, m_rd);
      chk("R5 irq_od_en model", {7'b0, irq_od_en}, {7'b0, (m_st == 1)});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] v, input bit with_fall);
    wr_stb = 1'b1; wr_data = v; scl_fall = with_fall;
    @(negedge clk);
    wr_stb = 1'b0; scl_fall = 1'b0;
  endtask

  task automatic pulse_ack_rd();
    ack_rd_rise = 1'b1; @(negedge clk); ack_rd_rise = 1'b0;
  endtask

  task automatic pulse_ack_wr();
    ack_wr_fall = 1'b1; @(negedge clk); ack_wr_fall = 1'b0;
  endtask

  task automatic pulse_rise();
    scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic pulse_fall();
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic pulse_cap();
    cap_stb = 1'b1; @(negedge clk); cap_stb = 1'b0;
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    live = 1'b1;
    // R1: reset state
    chk("R1 pull_dn_en", pull_dn_en, 8'h00);
    chk("R1 strong_pu_en", strong_pu_en, 8'h00);
    chk("R1 rd_data", rd_data, 8'hFF);
    chk("R1 irq_od_en", {7'b0, irq_od_en}, 8'h00);

    // R2 / R3: latch and strong pulse
    wr(8'hA5, 1'b0);
    chk("R2 pull_dn after write", pull_dn_en, 8'h5A);
    chk("R3 pulse on written ones", strong_pu_en, 8'hA5);
    step(3);
    chk("R3 pulse held until falling edge", strong_pu_en, 8'hA5);
    pulse_fall();
    chk("R3 pulse released", strong_pu_en, 8'h00);

    // R4: write and falling edge together
    wr(8'h0F, 1'b1);
    chk("R4 write wins over falling edge", strong_pu_en, 8'h0F);
    wr(8'hFF, 1'b0);
    pulse_fall();

    // R5: falling change on bit 3
    pin_in = 8'hF7;
    step(2);
    chk("R5 not yet after two edges", {7'b0, irq_od_en}, 8'h00);
    step(1);
    chk("R5 asserted after third edge", {7'b0, irq_od_en}, 8'h01);

    // R8: return to baseline
    pin_in = 8'hFF;
    step(3);
    chk("R8 released on return", {7'b0, irq_od_en}, 8'h00);

    // R6: read acknowledge clear and rebaseline
    pin_in = 8'hF7;
    step(4);
    chk("R5 asserted again", {7'b0, irq_od_en}, 8'h01);
    pulse_ack_rd();
    chk("R6 cleared by read ack", {7'b0, irq_od_en}, 8'h00);
    step(4);
    pulse_rise();
    chk("R6 baseline took new pins", {7'b0, irq_od_en}, 8'h00);

    // R5 rising change, R7 write acknowledge clear, R9 hold-off
    pin_in = 8'hFF;
    step(4);
    chk("R5 rising change asserts", {7'b0, irq_od_en}, 8'h01);
    pulse_ack_wr();
    chk("R7 cleared by write ack", {7'b0, irq_od_en}, 8'h00);
    pin_in = 8'hEF;
    step(5);
    chk("R9 held until rising edge", {7'b0, irq_od_en}, 8'h00);
    pulse_rise();
    chk("R9 asserted after rising edge", {7'b0, irq_od_en}, 8'h01);

    // R10: other events do not clear
    pulse_rise(); pulse_fall(); pulse_cap(); wr(8'hFF, 1'b0);
    step(1);
    chk("R10 still asserted", {7'b0, irq_od_en}, 8'h01);

    // R11: capture ignores the latch
    wr(8'h00, 1'b0);
    pin_in = 8'h3C;
    step(3);
    pulse_cap();
    chk("R11 read byte from pins", rd_data, 8'h3C);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      wr_stb      = ($urandom_range(0, 9) == 0);
      wr_data     = 8'($urandom);
      cap_stb     = ($urandom_range(0, 7) == 0);
      ack_rd_rise = ($urandom_range(0, 19) == 0);
      ack_wr_fall = ($urandom_range(0, 19) == 0);
      scl_rise    = ($urandom_range(0, 5) == 0);
      scl_fall    = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0) pin_in = pin_in ^ (8'h1 << $urandom_range(0, 7));
      @(negedge clk);
    end
    wr_stb = 0; cap_stb = 0; ack_rd_rise = 0; ack_wr_fall = 0; scl_rise = 0; scl_fall = 0;
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule